// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Output

This block drives a clock pin from a fast base clock (nominally 48 MHz). A 4-bit divisor N sets the output period to N+1 base cycles, so the pin carries 48 MHz at N=0 and 3 MHz at N=15. Software may rewrite the divisor at any moment. The new value is held pending and takes effect only where a fresh output period begins, so a change never creates a shortened high or low phase.

A suspend request starts a delay counter. The counter length is a parameter: 96,000 base cycles, about 2 ms at 48 MHz. Dropping the request before the count ends clears the counter. When the delay expires, two control bits select what happens. The first bit decides whether the pin hands over to an externally supplied slow clock. The second decides whether the block tells the clock source to stop. Each handover between the divided clock and the slow clock passes through a gap in which both sources are gated off. When suspend ends, the pin goes back to the divided clock.

Top module: `clkout_gen`

## Requirements
- R1: The output period is N+1 base-clock cycles. N is configuration bits [3:0].
- R2: The high phase lasts ceil((N+1)/2) base cycles and the low phase lasts floor((N+1)/2) base cycles. At N=0 the base clock appears on the output unchanged.
- R3: After reset the configuration reads back 0x03: N=3 (ratio 4) and both control bits are 0. The stop-request output `core_clk_en` is 1.
- R4: A new N takes effect only at the next rising edge of the divided output. During a change, no output phase is shorter than the phases of the old and new ratios.
- R5: Suppose `susp_req` is held high and the keep-running bit (bit 5) is 0. Then `core_clk_en` falls DELAY_CYC+1 cycles after the first clock edge that samples the request high. Any cycle with the request low restarts the count. Dropping the request raises `core_clk_en` again within two cycles.
- R6: With the keep-running bit at 1, `core_clk_en` stays 1 throughout suspend.
- R7: Suppose the slow-clock-disable bit (bit 4) is 0. Once the delay expires, the output follows `slow_clk` after a two-flop synchroniser. With bit 4 at 1, the output keeps the divided clock through suspend.
- R8: When suspend ends, the output returns to the divided clock. The divided and slow sources are never gated onto the output together. A gate opens or closes only while its source is low.
- R9: The configuration changes only on a write. `cfg_rdata` shows the stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Write data: [3:0] N, [4] slow-clock disable, [5] keep running |
| cfg_rdata | output | 6 | Stored configuration, same layout |
| susp_req | input | 1 | Suspend request, synchronous to clk |
| slow_clk | input | 1 | Low-power slow clock, asynchronous |
| clk_out | output | 1 | Clock output pin |
| core_clk_en | output | 1 | 0 requests the base clock source to stop |

## Verification
A divisor rewrite and the return from suspend can act in the same cycle. The bench provokes this by pulsing the write strobe with a new N in the same cycle that it drops the suspend request while the slow clock is on the pin. It then checks three things. The divided clock comes back at the new ratio. `core_clk_en` recovers. No high or low run seen during the whole return is shorter than the new ratio's shortest phase.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  // Handover state between divided clock and slow clock
  typedef enum logic [1:0] {
    HO_DIV     = 2'd0,
    HO_TO_SLOW = 2'd1,
    HO_SLOW    = 2'd2,
    HO_TO_DIV  = 2'd3
  } ho_state_t;

  // Control flags held next to the divisor
  typedef struct packed {
    logic keep_run;
    logic no_slow;
  } mode_t;

endpackage

// File: rtl/clkout_cfg.sv
module clkout_cfg
  import clkout_pkg::*;
#(
  parameter int DIV_W   = 4,
  parameter int RST_DIV = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [DIV_W+1:0] wdata,
  output logic [DIV_W-1:0] div_n,
  output mode_t            mode,
  output logic [DIV_W+1:0] rdata
);

  localparam int NOSLOW_BIT = DIV_W;
  localparam int KEEP_BIT   = DIV_W + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_n <= DIV_W'(RST_DIV);
      mode  <= '0;
    end else if (we) begin
      div_n         <= wdata[DIV_W-1:0];
      mode.no_slow  <= wdata[NOSLOW_BIT];
      mode.keep_run <= wdata[KEEP_BIT];
    end
  end

  assign rdata = {mode.keep_run, mode.no_slow, div_n};

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(rdata));

endmodule

// File: rtl/clkout_div.sv
module clkout_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             div_hi,
  output logic             pass,
  output logic             nxt_hi,
  output logic             nxt_pass
);

  localparam int HW = DIV_W + 1;

  logic [DIV_W-1:0] pc, n_act;
  logic [DIV_W-1:0] nxt_pc, nxt_n;
  logic [HW-1:0]    hi_len;
  logic             wrap;

  always_comb begin
    wrap     = (pc == n_act);
    nxt_n    = wrap ? div_cfg : n_act;
    nxt_pc   = wrap ? '0 : pc + 1'b1;
    hi_len   = ({1'b0, nxt_n} + HW'(2)) >> 1;
    nxt_hi   = ({1'b0, nxt_pc} < hi_len);
    nxt_pass = (nxt_n == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      n_act  <= '0;
      div_hi <= 1'b0;
      pass   <= 1'b0;
    end else begin
      pc     <= nxt_pc;
      n_act  <= nxt_n;
      div_hi <= nxt_hi;
      pass   <= nxt_pass;
    end
  end

  // R1
  pc_range_chk: assert property (@(posedge clk) disable iff (rst)
    pc <= n_act);

  // R4
  ratio_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(n_act) |-> $past(pc == n_act));

  // R2
  hi_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(div_hi) |-> (pc == '0));

endmodule

// File: rtl/clkout_susp_tmr.sv
module clkout_susp_tmr #(
  parameter int DELAY_CYC = 96000
) (
  input  logic clk,
  input  logic rst,
  input  logic susp_req,
  input  logic keep_run,
  output logic expired,
  output logic core_clk_en
);

  localparam int CNT_W = $clog2(DELAY_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      expired     <= 1'b0;
      core_clk_en <= 1'b1;
    end else begin
      core_clk_en <= !(expired && !keep_run);
      if (!susp_req) begin
        cnt     <= '0;
        expired <= 1'b0;
      end else if (!expired) begin
        if (cnt == LAST) expired <= 1'b1;
        else             cnt     <= cnt + 1'b1;
      end
    end
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R5
  core_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_clk_en) |-> $past(susp_req));

  // R6
  keep_run_chk: assert property (@(posedge clk) disable iff (rst)
    keep_run |=> core_clk_en);

endmodule

// File: rtl/clkout_handover.sv
module clkout_handover
  import clkout_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic want_slow,
  input  logic slow_clk,
  input  logic div_hi,
  input  logic pass,
  input  logic nxt_hi,
  input  logic nxt_pass,
  output logic clk_out
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic slow_s, nxt_slow, div_ok, slow_ok;
  logic g_div, g_slow;
  ho_state_t st;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], slow_clk};
  end

  assign slow_s   = sync_q[SYNC_STAGES-1];
  assign nxt_slow = sync_q[SYNC_STAGES-2];
  assign div_ok   = !nxt_hi || nxt_pass;
  assign slow_ok  = !nxt_slow;

  always_ff @(posedge clk) begin
    if (rst) st <= HO_DIV;
    else begin
      unique case (st)
        HO_DIV:     if (want_slow && div_ok) st <= HO_TO_SLOW;
        HO_TO_SLOW: if (!want_slow && div_ok)     st <= HO_DIV;
                    else if (want_slow && slow_ok) st <= HO_SLOW;
        HO_SLOW:    if (!want_slow && slow_ok) st <= HO_TO_DIV;
        HO_TO_DIV:  if (want_slow && slow_ok)      st <= HO_SLOW;
                    else if (!want_slow && div_ok) st <= HO_DIV;
        default:    st <= HO_DIV;
      endcase
    end
  end

  // gates move on the falling edge, while the chosen source is low
  always_ff @(negedge clk) begin
    if (rst) begin
      g_div  <= 1'b1;
      g_slow <= 1'b0;
    end else begin
      g_div  <= (st == HO_DIV);
      g_slow <= (st == HO_SLOW);
    end
  end

  assign clk_out = (g_div & (pass ? clk : div_hi)) | (g_slow & slow_s);

  // R8
  gate_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({g_div, g_slow}));

  // R8
  div_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(g_div) || $fell(g_div)) |-> (!div_hi || pass));

  // R7
  slow_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(g_slow) || $fell(g_slow)) |-> !slow_s);

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
  import clkout_pkg::*;
#(
  parameter int DIV_W       = 4,
  parameter int RST_DIV     = 3,
  parameter int DELAY_CYC   = 96000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [DIV_W+1:0] cfg_wdata,
  output logic [DIV_W+1:0] cfg_rdata,
  input  logic             susp_req,
  input  logic             slow_clk,
  output logic             clk_out,
  output logic             core_clk_en
);

  logic [DIV_W-1:0] div_n;
  mode_t            mode;
  logic             div_hi, pass, nxt_hi, nxt_pass;
  logic             expired, want_slow;

  clkout_cfg #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .div_n(div_n), .mode(mode), .rdata(cfg_rdata)
  );

  clkout_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div_cfg(div_n),
    .div_hi(div_hi), .pass(pass), .nxt_hi(nxt_hi), .nxt_pass(nxt_pass)
  );

  clkout_susp_tmr #(.DELAY_CYC(DELAY_CYC)) u_tmr (
    .clk(clk), .rst(rst), .susp_req(susp_req), .keep_run(mode.keep_run),
    .expired(expired), .core_clk_en(core_clk_en)
  );

  assign want_slow = expired && !mode.no_slow;

  clkout_handover #(.SYNC_STAGES(SYNC_STAGES)) u_ho (
    .clk(clk), .rst(rst), .want_slow(want_slow), .slow_clk(slow_clk),
    .div_hi(div_hi), .pass(pass), .nxt_hi(nxt_hi), .nxt_pass(nxt_pass),
    .clk_out(clk_out)
  );

endmodule

// File: tb/clkout_gen_test.sv
module clkout_gen_test;

  localparam int DLY = 64;

  logic       clk = 1'b0, rst = 1'b1, cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [5:0] cfg_rdata;
  logic       susp_req = 1'b0, slow_clk = 1'b0;
  logic       clk_out, core_clk_en;

  always #4 clk = ~clk;

  clkout_gen #(.DELAY_CYC(DLY)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .susp_req(susp_req), .slow_clk(slow_clk),
    .clk_out(clk_out), .core_clk_en(core_clk_en)
  );

  int n_chk = 0, n_fail = 0;
  int q_lvl[$], q_len[$];
  string q_req[$];
  bit armed = 0, started = 0, win = 0;
  int glitch_min = 999;
  logic prev_s = 1'b0;
  int run_len = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_done(logic lvl, int len);
    if (win && len < glitch_min) glitch_min = len;
    if (started && q_len.size() > 0)
      check(q_req.pop_front(), lvl * 1000 + len,
            q_lvl.pop_front() * 1000 + q_len.pop_front());
    if (armed && q_len.size() == 0) begin
      armed = 0;
      started = 0;
    end
  endtask

  task automatic sample();
    logic s;
    s = clk_out;
    if (s === prev_s) run_len++;
    else begin
      run_done(prev_s, run_len);
      prev_s = s;
      run_len = 1;
      if (armed && !started && s === 1'b1) started = 1;
    end
  endtask

  // monitor: half-cycle samples of the pin, compared against the queue
  initial begin
    forever begin
      @(posedge clk); #2; sample();
      @(negedge clk); #2; sample();
    end
  end

  // slow clock: 40 base cycles per period
  initial forever begin
    repeat (20) @(posedge clk);
    #1 slow_clk = ~slow_clk;
  end

  task automatic expect_runs(string req, int hi, int lo, int periods);
    for (int p = 0; p < periods; p++) begin
      q_lvl.push_back(1); q_len.push_back(hi); q_req.push_back(req);
      q_lvl.push_back(0); q_len.push_back(lo); q_req.push_back(req);
    end
    armed = 1;
    for (int t = 0; t < 3000 && armed; t++) @(posedge clk);
    if (armed) begin
      check(req, q_len.size(), 0);
      q_lvl.delete(); q_len.delete(); q_req.delete();
      armed = 0; started = 0;
    end
  endtask

  task automatic expect_ratio(string req, int r, int periods);
    if (r == 1) expect_runs(req, 1, 1, periods);
    else        expect_runs(req, 2 * ((r + 1) / 2), 2 * (r / 2), periods);
  endtask

  task automatic wr(logic [5:0] v);
    @(negedge clk); #1 cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic measure_fall(output int cnt);
    @(negedge clk); #1 susp_req = 1'b1;
    cnt = 0;
    do begin
      @(posedge clk); #2;
      cnt++;
    end while (core_clk_en && cnt < DLY * 4);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int cnt, bad;
    repeat (5) @(posedge clk);
    @(negedge clk); #1 rst = 1'b0;
    @(negedge clk); #1;
    // R3 reset state
    check("R3", cfg_rdata, 6'h03);
    check("R3", core_clk_en, 1);
    expect_ratio("R3", 4, 2);

    // R1 / R2 several ratios
    wr(6'd0);  repeat (40) @(posedge clk); expect_ratio("R2", 1, 2);
    wr(6'd1);  repeat (40) @(posedge clk); expect_ratio("R1", 2, 2);
    wr(6'd2);  repeat (40) @(posedge clk); expect_ratio("R2", 3, 2);
    wr(6'd5);  repeat (40) @(posedge clk); expect_ratio("R1", 6, 2);
    wr(6'd15); repeat (60) @(posedge clk); expect_ratio("R1", 16, 2);

    // R4 change in mid high phase
    wr(6'd7); repeat (40) @(posedge clk);
    @(posedge clk_out);
    glitch_min = 999; win = 1;
    wr(6'd1);
    expect_ratio("R4", 2, 3);
    win = 0;
    check("R4", glitch_min >= 2, 1);

    // R5 delay, then R7 slow clock on pin
    wr(6'd3);
    measure_fall(cnt);
    check("R5", cnt, DLY + 1);
    repeat (100) @(posedge clk);
    expect_runs("R7", 40, 40, 2);

    // R8 new divisor written in the same cycle suspend ends
    glitch_min = 999; win = 1;
    @(negedge clk); #1 cfg_we = 1'b1; cfg_wdata = 6'd2; susp_req = 1'b0;
    @(negedge clk); #1 cfg_we = 1'b0;
    repeat (3) @(posedge clk); #2;
    check("R5", core_clk_en, 1);
    repeat (80) @(posedge clk);
    expect_ratio("R8", 3, 3);
    win = 0;
    check("R8", glitch_min >= 2, 1);

    // R5 restart after a one-cycle drop
    wr(6'd3);
    @(negedge clk); #1 susp_req = 1'b1;
    repeat (DLY / 2) @(negedge clk);
    #1 susp_req = 1'b0;
    measure_fall(cnt);
    check("R5", cnt, DLY + 1);
    @(negedge clk); #1 susp_req = 1'b0;
    repeat (80) @(posedge clk);

    // R6 keep running
    wr(6'h23);
    @(negedge clk); #1 susp_req = 1'b1;
    bad = 0;
    for (int i = 0; i < DLY + 40; i++) begin
      @(posedge clk); #2;
      if (core_clk_en !== 1'b1) bad++;
    end
    check("R6", bad, 0);
    @(negedge clk); #1 susp_req = 1'b0;
    repeat (80) @(posedge clk);

    // R7 slow clock disabled: divided clock stays
    wr(6'h33);
    @(negedge clk); #1 susp_req = 1'b1;
    repeat (DLY + 40) @(posedge clk);
    expect_ratio("R7", 4, 2);
    @(negedge clk); #1 susp_req = 1'b0;

    // R9 readback and hold
    check("R9", cfg_rdata, 6'h33);
    wr(6'h15);
    check("R9", cfg_rdata, 6'h15);
    repeat (50) @(posedge clk);
    #2;
    check("R9", cfg_rdata, 6'h15);

    finish_run();
  end

endmodule